// File: doc/BRIEF.md
# Low-Power Mode Controller

This block controls the reduced-power states of a small 8-bit microcontroller. A divide-by-two stage, driven by the raw oscillator input, makes the internal clock. The block emits that clock as two enables: one for the CPU core and one for the on-chip peripherals. A third output tells the oscillator whether to keep running.

The CPU asks for a mode by writing the power-control register. A write strobe is qualified by two bits: idle request and power-down request. The write is taken on an internal clock tick. The mode starts from the next tick, so the write is the last CPU operation before the mode begins.

The two modes end differently:
- In idle, the CPU is gated while the peripherals keep running. Idle ends on any enabled pending interrupt or on reset.
- In power-down, the oscillator and both enables stop. Only the asynchronous hardware reset ends power-down.

Top module: `lpm_ctrl`

## Requirements
- R1: `per_ce` is high on every second `clk_in` cycle only. After reset is released, it is first high in the cycle that follows the first rising edge. `cpu_ce` is never high when `per_ce` is low.
- R2: A tick with `pcon_we`=1, `req_idle`=1 and `req_pd`=0 enters idle. From the next tick on, `cpu_ce` stays 0 and `per_ce` keeps pulsing.
- R3: In idle, a tick with `irq_pend`=1 returns the block to normal mode, which clears the idle state. `cpu_ce` pulses again from the next tick.
- R4: Asserting `rst` at any time, in any mode, sets `mode` to 00 at once and drives `osc_run` to 1. After release, the enables follow R1.
- R5: In power-down, `osc_run`, `cpu_ce` and `per_ce` are all 0. `irq_pend` and register writes have no effect there, and only `rst` leaves the mode.
- R6: A tick with `pcon_we`=1 and `req_pd`=1 in normal mode enters power-down, whatever the value of `req_idle`.
- R7: `mode` reads 00 in normal mode, 01 in idle and 10 in power-down. It changes in the `clk_in` cycle that follows the tick that caused the change.
- R8: Writes count only in normal mode, so a write during idle is ignored. A write with both request bits 0 does nothing, and `irq_pend` in normal mode does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Raw oscillator input, of any duty cycle |
| rst | input | 1 | Asynchronous hardware reset, active high |
| pcon_we | input | 1 | Power-control register write strobe |
| req_idle | input | 1 | Idle request bit of the write |
| req_pd | input | 1 | Power-down request bit of the write |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| mode | output | 2 | Active mode: 00 normal, 01 idle, 10 power-down |

## Verification
A wrong mode state shows on `mode` one `clk_in` cycle after the tick that caused it. It shows on `cpu_ce` or `per_ce` at the next tick, two cycles later. A divider that slips phase or keeps toggling in power-down shows at once as `per_ce` high on the wrong cycle or while `osc_run` is low. Reset behaviour can be seen while `rst` is still asserted, because `mode` and `osc_run` change without waiting for a clock.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl (
  input  logic       clk_in,
  input  logic       rst,
  input  logic       pcon_we,
  input  logic       req_idle,
  input  logic       req_pd,
  input  logic       irq_pend,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic       osc_run,
  output logic [1:0] mode
);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_IDLE = 2'b01;
  localparam logic [1:0] M_PD   = 2'b10;

  logic       phase;
  logic [1:0] mode_q;
  logic [1:0] mode_d;

  assign osc_run = (mode_q != M_PD);
  assign per_ce  = phase & osc_run;
  assign cpu_ce  = phase & (mode_q == M_NORM);
  assign mode    = mode_q;

  always_comb begin
    mode_d = mode_q;
    if (phase) begin
      case (mode_q)
        M_NORM: if (pcon_we) begin
          if (req_pd)        mode_d = M_PD;
          else if (req_idle) mode_d = M_IDLE;
        end
        M_IDLE: if (irq_pend) mode_d = M_NORM;
        default: mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk_in or posedge rst) begin
    if (rst) begin
      phase  <= 1'b0;
      mode_q <= M_NORM;
    end else begin
      phase  <= phase ^ osc_run;
      mode_q <= mode_d;
    end
  end

  p_half_rate_r1: assert property (@(posedge clk_in) disable iff (rst)
    per_ce |=> !per_ce);
  p_cpu_under_per_r1: assert property (@(posedge clk_in) disable iff (rst)
    cpu_ce |-> per_ce);
  p_idle_entry_r2: assert property (@(posedge clk_in) disable iff (rst)
    (mode == M_NORM && per_ce && pcon_we && req_idle && !req_pd) |=> (mode == M_IDLE));
  p_idle_wake_r3: assert property (@(posedge clk_in) disable iff (rst)
    (mode == M_IDLE && per_ce && irq_pend) |=> (mode == M_NORM));
  p_pd_sticky_r5: assert property (@(posedge clk_in) disable iff (rst)
    (mode == M_PD) |=> (mode == M_PD && !per_ce));
  p_pd_prio_r6: assert property (@(posedge clk_in) disable iff (rst)
    (mode == M_NORM && per_ce && pcon_we && req_pd) |=> (mode == M_PD));
  p_mode_code_r7: assert property (@(posedge clk_in) disable iff (rst)
    mode != 2'b11);
  p_idle_write_ignored_r8: assert property (@(posedge clk_in) disable iff (rst)
    (mode == M_IDLE && !irq_pend) |=> (mode == M_IDLE));
endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  logic clk_in = 1'b0;
  logic rst = 1'b1;
  logic pcon_we = 1'b0, req_idle = 1'b0, req_pd = 1'b0, irq_pend = 1'b0;
  logic cpu_ce, per_ce, osc_run;
  logic [1:0] mode;
  int checks = 0, fails = 0;

  always #10 clk_in = ~clk_in;

  lpm_ctrl uut (
    .clk_in(clk_in), .rst(rst), .pcon_we(pcon_we), .req_idle(req_idle),
    .req_pd(req_pd), .irq_pend(irq_pend), .cpu_ce(cpu_ce), .per_ce(per_ce),
    .osc_run(osc_run), .mode(mode)
  );

  // {we, idle, pd, irq, mode[1:0], osc_run, cpu_ce, per_ce}
  localparam logic [8:0] VEC [0:9] = '{
    9'b0000_00_111,  // R7 normal no-op
    9'b1100_01_101,  // R2 enter idle
    9'b1010_01_101,  // R8 write during idle ignored
    9'b0001_00_111,  // R3 wake on interrupt
    9'b0001_00_111,  // R8 irq in normal ignored
    9'b1000_00_111,  // R8 empty write
    9'b1100_01_101,  // R2 idle again
    9'b1001_00_111,  // R3 wake, write ignored
    9'b1110_10_000,  // R6 both bits -> power-down
    9'b0001_10_000   // R5 irq in power-down ignored
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic release_rst();
    @(negedge clk_in) rst = 1'b0;
    @(negedge clk_in);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_in);
    chk("R4 reset mode", mode, 0);
    chk("R4 reset osc_run", osc_run, 1);
    release_rst();
    chk("R1 first tick per_ce", per_ce, 1);

    foreach (VEC[i]) begin
      logic [8:0] v;
      v = VEC[i];
      pcon_we = v[8]; req_idle = v[7]; req_pd = v[6]; irq_pend = v[5];
      @(negedge clk_in);
      chk($sformatf("R7 vec%0d mode", i), mode, v[4:3]);
      chk($sformatf("R5 vec%0d osc_run", i), osc_run, v[2]);
      chk($sformatf("R1 vec%0d off-tick per_ce", i), per_ce, 0);
      chk($sformatf("R1 vec%0d off-tick cpu_ce", i), cpu_ce, 0);
      pcon_we = 0; req_idle = 0; req_pd = 0; irq_pend = 0;
      @(negedge clk_in);
      chk($sformatf("R2 vec%0d cpu_ce", i), cpu_ce, v[1]);
      chk($sformatf("R2 vec%0d per_ce", i), per_ce, v[0]);
    end

    repeat (6) @(negedge clk_in);
    chk("R5 pd stays", mode, 2);
    chk("R5 pd no per_ce", per_ce, 0);

    rst = 1'b1; #1;
    chk("R4 reset leaves pd", mode, 0);
    chk("R4 reset osc on", osc_run, 1);
    release_rst();
    begin
      int cnt = 0;
      for (int k = 0; k < 10; k++) begin
        if (per_ce) cnt++;
        if (k % 2 == 0) chk("R1 phase", per_ce, 1);
        else chk("R1 phase", per_ce, 0);
        @(negedge clk_in);
      end
      chk("R1 pulse count", cnt, 5);
    end

    pcon_we = 1; req_idle = 1;
    @(negedge clk_in);
    pcon_we = 0; req_idle = 0;
    chk("R2 idle", mode, 1);
    @(negedge clk_in);
    rst = 1'b1; #1;
    chk("R4 reset leaves idle", mode, 0);
    release_rst();
    chk("R4 cpu_ce after reset", cpu_ce, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule